// File: doc/BRIEF.md
# Coin Payphone Call Controller

This block sequences one call on a coin-operated telephone. It follows the handset from lifting, through the required coin and the line outcome (busy or connected), into a talk period measured in slots of second ticks. Near the end of each slot it asks the caller for another coin. A coin inserted in response buys one more slot. A busy line gives the coin back when the caller hangs up. A connected call keeps the coin.

A line fault overrides all other behaviour and parks the controller in an out-of-order state. The controller leaves that state only once the fault has cleared and the handset is on hook. The slot length and the point at which the prompt appears are parameters counted in second ticks. The defaults are a 60-tick slot with the prompt after the 45th tick.

Top module: `payphone_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, state is IDLE (code 0) and coin_return_o, coin_collect_o, talk_en_o, coin_prompt_o and out_of_order_o are all low.
- R2: In IDLE, off hook moves the state to WAIT_COIN (code 1). Returning on hook before a coin is inserted goes back to IDLE with no coin_return_o pulse.
- R3: A coin in WAIT_COIN moves the state to WAIT_LINE (code 2). line_conn_i in WAIT_LINE moves it to TALK (code 4). talk_en_o is high exactly while the state is TALK.
- R4: line_busy_i in WAIT_LINE moves the state to BUSY (code 3). On hook in BUSY or in WAIT_LINE returns to IDLE and gives a one-cycle coin_return_o pulse on the same edge.
- R5: coin_prompt_o rises on the edge of the PROMPT_AT-th tick of a slot. It stays high until a coin is inserted or the slot ends, and it is never high outside TALK.
- R6: A coin inserted while coin_prompt_o is high clears the prompt on the next edge. When the slot's SLOT_LEN-th tick arrives, the call stays in TALK with a fresh slot, and coin_collect_o pulses once.
- R7: If no coin was taken during the prompt, the SLOT_LEN-th tick of the slot moves the state to ENDED (code 5), drops talk_en_o and pulses coin_collect_o once. Coins inserted in TALK outside the prompt window have no effect.
- R8: ENDED stays put while the handset is off hook and goes to IDLE on hook. A new call is possible only from IDLE.
- R9: On hook during TALK ends the call on that edge. The state becomes IDLE, coin_collect_o pulses once and coin_return_o stays low.
- R10: line_fault_i high moves every state to OUT_OF_ORDER (code 6) on the next edge, with out_of_order_o high and talk_en_o and coin_prompt_o low. The state leaves only when the fault is low and the handset is on hook, and it goes to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| off_hook_i | input | 1 | Handset lifted (level) |
| coin_in_i | input | 1 | One-cycle pulse per accepted coin |
| line_busy_i | input | 1 | Called line reports busy |
| line_conn_i | input | 1 | Called line reports connected |
| line_fault_i | input | 1 | Line fault present (level) |
| coin_return_o | output | 1 | One-cycle pulse: give the held coin back |
| coin_collect_o | output | 1 | One-cycle pulse: keep the held coin |
| talk_en_o | output | 1 | Voice path enabled |
| coin_prompt_o | output | 1 | Ask the caller for another coin |
| out_of_order_o | output | 1 | Controller is in the fault state |
| state_o | output | 3 | Current state code |

## Verification
State, prompt and the two coin pulses are all registered. Each of them reflects the inputs seen at one clock edge and is visible right after that edge, so every result is due one cycle after its stimulus. The bench drives inputs just after a rising edge, lets a single edge pass, and then samples. It tallies the coin pulses cycle by cycle so that no pulse is missed. The slot is shrunk to 6 ticks with the prompt at 4, and the coin is swept across every tick position of the slot. The expected outcome (renewed or ended) and the pulse counts are computed from the tick index.

// File: rtl/payphone_pkg.sv
// Shared state encoding for the payphone call controller.
// Assumes: the codes are visible on the state port and are relied on by users.
package payphone_pkg;
    typedef enum logic [2:0] {
        PP_IDLE      = 3'd0,
        PP_WAIT_COIN = 3'd1,
        PP_WAIT_LINE = 3'd2,
        PP_BUSY      = 3'd3,
        PP_TALK      = 3'd4,
        PP_ENDED     = 3'd5,
        PP_OOO       = 3'd6
    } pp_state_t;
endpackage

// File: rtl/pp_slot_timer.sv
// Slot timer: counts second ticks while a call is in the talk state.
// It strobes at the prompt point and at the end of each slot, and it wraps to zero
// at the slot end so that a renewed slot starts counting at once.
// Assumes: 0 < PROMPT_AT < SLOT_LEN, and ticks are single-cycle pulses.
module pp_slot_timer #(
    parameter int SLOT_LEN  = 60,
    parameter int PROMPT_AT = 45,
    localparam int CW = $clog2(SLOT_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic prompt_hit_o,
    output logic slot_end_o
);
    logic [CW-1:0] cnt_q;

    assign prompt_hit_o = run_i && tick_i && (cnt_q == CW'(PROMPT_AT - 1));
    assign slot_end_o   = run_i && tick_i && (cnt_q == CW'(SLOT_LEN - 1));

    // Elapsed ticks in the current slot; held at zero outside the talk state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= slot_end_o ? '0 : cnt_q + 1'b1;
    end

    AST_CNT_BELOW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(SLOT_LEN)); // R7
endmodule

// File: rtl/pp_call_fsm.sv
// Call sequencer: hook, coin, line outcome, talk slots with a top-up prompt,
// coin return or collection, and the fault override.
// Assumes: coin_in_i is a single-cycle pulse, and the timer strobes are valid only in TALK.
module pp_call_fsm
    import payphone_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      off_hook_i,
    input  logic      coin_in_i,
    input  logic      line_busy_i,
    input  logic      line_conn_i,
    input  logic      line_fault_i,
    input  logic      prompt_hit_i,
    input  logic      slot_end_i,
    output pp_state_t state_o,
    output logic      prompt_o,
    output logic      coin_return_o,
    output logic      coin_collect_o
);
    pp_state_t state_q;
    logic      prompt_q;
    logic      credit_q;

    // State, prompt, prepaid credit and the one-cycle coin pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= PP_IDLE;
            prompt_q       <= 1'b0;
            credit_q       <= 1'b0;
            coin_return_o  <= 1'b0;
            coin_collect_o <= 1'b0;
        end else begin
            coin_return_o  <= 1'b0;
            coin_collect_o <= 1'b0;
            if (line_fault_i) begin
                state_q  <= PP_OOO;
                prompt_q <= 1'b0;
                credit_q <= 1'b0;
            end else begin
                case (state_q)
                    PP_IDLE:
                        if (off_hook_i) state_q <= PP_WAIT_COIN;
                    PP_WAIT_COIN:
                        if (!off_hook_i)    state_q <= PP_IDLE;
                        else if (coin_in_i) state_q <= PP_WAIT_LINE;
                    PP_WAIT_LINE:
                        if (!off_hook_i) begin
                            state_q       <= PP_IDLE;
                            coin_return_o <= 1'b1;
                        end else if (line_busy_i) begin
                            state_q <= PP_BUSY;
                        end else if (line_conn_i) begin
                            state_q <= PP_TALK;
                        end
                    PP_BUSY:
                        if (!off_hook_i) begin
                            state_q       <= PP_IDLE;
                            coin_return_o <= 1'b1;
                        end
                    PP_TALK:
                        if (!off_hook_i) begin
                            state_q        <= PP_IDLE;
                            coin_collect_o <= 1'b1;
                            prompt_q       <= 1'b0;
                            credit_q       <= 1'b0;
                        end else if (slot_end_i) begin
                            coin_collect_o <= 1'b1;
                            prompt_q       <= 1'b0;
                            if (credit_q) credit_q <= 1'b0;
                            else          state_q  <= PP_ENDED;
                        end else if (prompt_q && coin_in_i) begin
                            credit_q <= 1'b1;
                            prompt_q <= 1'b0;
                        end else if (prompt_hit_i && !credit_q) begin
                            prompt_q <= 1'b1;
                        end
                    PP_ENDED:
                        if (!off_hook_i) state_q <= PP_IDLE;
                    PP_OOO:
                        if (!off_hook_i) state_q <= PP_IDLE;
                    default:
                        state_q <= PP_IDLE;
                endcase
            end
        end
    end

    assign state_o  = state_q;
    assign prompt_o = prompt_q;

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        line_fault_i |=> state_q == PP_OOO); // R10
    AST_OOO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PP_OOO && state_q != PP_OOO) |->
        (!$past(line_fault_i) && !$past(off_hook_i) && state_q == PP_IDLE)); // R10
    AST_PROMPT_IN_TALK: assert property (@(posedge clk) disable iff (!rst_n)
        prompt_q |-> state_q == PP_TALK); // R5
    AST_RETURN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coin_return_o) |-> ($past(state_q) == PP_BUSY || $past(state_q) == PP_WAIT_LINE)); // R4
    AST_HANGUP_COLLECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PP_TALK && !off_hook_i && !line_fault_i) |=>
        (state_q == PP_IDLE && coin_collect_o && !coin_return_o)); // R9
endmodule

// File: rtl/payphone_ctrl.sv
// Top of the coin payphone call controller: joins the slot timer to the call sequencer
// and decodes the level outputs from the state.
// Assumes: all inputs are synchronous to clk.
module payphone_ctrl #(
    parameter int SLOT_LEN  = 60,
    parameter int PROMPT_AT = 45
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick_i,
    input  logic       off_hook_i,
    input  logic       coin_in_i,
    input  logic       line_busy_i,
    input  logic       line_conn_i,
    input  logic       line_fault_i,
    output logic       coin_return_o,
    output logic       coin_collect_o,
    output logic       talk_en_o,
    output logic       coin_prompt_o,
    output logic       out_of_order_o,
    output logic [2:0] state_o
);
    import payphone_pkg::*;

    pp_state_t st;
    logic      prompt_hit;
    logic      slot_end;

    pp_slot_timer #(.SLOT_LEN(SLOT_LEN), .PROMPT_AT(PROMPT_AT)) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (st == PP_TALK),
        .tick_i       (sec_tick_i),
        .prompt_hit_o (prompt_hit),
        .slot_end_o   (slot_end)
    );

    pp_call_fsm fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .off_hook_i     (off_hook_i),
        .coin_in_i      (coin_in_i),
        .line_busy_i    (line_busy_i),
        .line_conn_i    (line_conn_i),
        .line_fault_i   (line_fault_i),
        .prompt_hit_i   (prompt_hit),
        .slot_end_i     (slot_end),
        .state_o        (st),
        .prompt_o       (coin_prompt_o),
        .coin_return_o  (coin_return_o),
        .coin_collect_o (coin_collect_o)
    );

    assign talk_en_o      = (st == PP_TALK);
    assign out_of_order_o = (st == PP_OOO);
    assign state_o        = st;
endmodule

// File: tb/payphone_ctrl_tb.sv
// Bench for the payphone controller, run with a small slot (6 ticks, prompt at 4).
module payphone_ctrl_tb_top;
    localparam int SLOT = 6;
    localparam int PRM  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, hook = 1'b0, coin = 1'b0, busy = 1'b0, conn = 1'b0, fault = 1'b0;
    logic ret, col, talk, prm, ooo;
    logic [2:0] st;
    int n_chk = 0, n_bad = 0, n_ret = 0, n_col = 0;

    always #4 clk = ~clk;

    payphone_ctrl #(.SLOT_LEN(SLOT), .PROMPT_AT(PRM)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(tick), .off_hook_i(hook),
        .coin_in_i(coin), .line_busy_i(busy), .line_conn_i(conn), .line_fault_i(fault),
        .coin_return_o(ret), .coin_collect_o(col), .talk_en_o(talk),
        .coin_prompt_o(prm), .out_of_order_o(ooo), .state_o(st)
    );

    task automatic step();
        @(posedge clk); #1;
        if (ret) n_ret++;
        if (col) n_col++;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    task automatic go_talk();
        hook = 1'b1; step();
        coin = 1'b1; step(); coin = 1'b0;
        conn = 1'b1; step(); conn = 1'b0;
    endtask

    task automatic to_idle();
        hook = 1'b0; step(); step();
        n_ret = 0; n_col = 0;
    endtask

    // Bring the controller from IDLE to the given state code.
    task automatic reach(input int s);
        case (s)
            1: begin hook = 1'b1; step(); end
            2: begin hook = 1'b1; step(); coin = 1'b1; step(); coin = 1'b0; end
            3: begin hook = 1'b1; step(); coin = 1'b1; step(); coin = 1'b0;
                     busy = 1'b1; step(); busy = 1'b0; end
            4: go_talk();
            5: begin go_talk(); ticks(SLOT); end
            default: ;
        endcase
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 state in reset", st, 0);
        rst_n = 1'b1; step();
        chk("R1 state after reset", st, 0);
        chk("R1 outputs after reset", {ret, col, talk, prm, ooo}, 0);

        // R2: lift, then hang up without a coin.
        hook = 1'b1; step();
        chk("R2 off hook", st, 1);
        hook = 1'b0; step();
        chk("R2 abort to idle", st, 0);
        chk("R2 no return", n_ret, 0);
        to_idle();

        // R3: coin then connect.
        reach(2);
        chk("R3 wait line", st, 2);
        chk("R3 talk low before connect", talk, 0);
        conn = 1'b1; step(); conn = 1'b0;
        chk("R3 talk state", st, 4);
        chk("R3 talk enable", talk, 1);
        to_idle();

        // R4: busy then hang up returns coin; hang up while waiting returns too.
        reach(3);
        chk("R4 busy state", st, 3);
        hook = 1'b0; step();
        chk("R4 busy hangup idle", st, 0);
        chk("R4 busy return pulse", ret, 1);
        step();
        chk("R4 return single pulse", n_ret, 1);
        to_idle();
        reach(2);
        hook = 1'b0; step();
        chk("R4 wait-line hangup return", n_ret, 1);
        chk("R4 wait-line hangup state", st, 0);
        to_idle();

        // R5, R6, R7: coin at every tick position of the first slot.
        for (int k = 0; k < SLOT; k++) begin
            automatic bit renew = (k >= PRM);
            go_talk();
            ticks(k);
            chk($sformatf("R5 prompt after %0d ticks", k), prm, renew);
            coin = 1'b1; step(); coin = 1'b0;
            chk($sformatf("R6 prompt cleared by coin k=%0d", k), prm, 0);
            ticks(SLOT - k);
            chk($sformatf("R6/R7 state at slot end k=%0d", k), st, renew ? 4 : 5);
            chk($sformatf("R7 collect count k=%0d", k), n_col, 1);
            chk($sformatf("R7 talk at slot end k=%0d", k), talk, renew);
            if (renew) begin
                ticks(PRM);
                chk("R5 prompt in renewed slot", prm, 1);
                ticks(SLOT - PRM);
                chk("R6 second slot ends", st, 5);
                chk("R6 collect count after two slots", n_col, 2);
                chk("R5 prompt low after end", prm, 0);
            end
            // R8: ended holds while off hook.
            step(); step();
            chk("R8 ended holds", st, 5);
            hook = 1'b0; step();
            chk("R8 ended to idle", st, 0);
            to_idle();
        end

        // R9: hang up mid call.
        go_talk(); ticks(2);
        hook = 1'b0; step();
        chk("R9 hangup idle", st, 0);
        chk("R9 collect pulse", col, 1);
        chk("R9 no return", n_ret, 0);
        to_idle();

        // R10: fault from every state.
        for (int s = 0; s < 6; s++) begin
            reach(s);
            fault = 1'b1; step();
            chk($sformatf("R10 fault from state %0d", s), st, 6);
            chk("R10 out_of_order high", ooo, 1);
            chk("R10 talk and prompt low", {talk, prm}, 0);
            hook = 1'b0; step();
            chk("R10 holds while fault", st, 6);
            hook = 1'b1; fault = 1'b0; step();
            chk("R10 holds off hook", st, 6);
            hook = 1'b0; step();
            chk("R10 exits to idle", st, 0);
            to_idle();
        end

        report();
        $finish;
    end
endmodule